// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column address for every beat of a memory burst. A controller pulses a start strobe together with a starting column. The block then steps through the remaining columns of the burst without further input. The order of those columns follows the programmed burst length code and the burst type.

With a fixed length of 2, 4 or 8, the low address bits walk through an aligned block of that size. A sequential burst wraps inside that block. An interleaved burst XORs the beat index into the start column. With the full-page code the whole column counts upward and wraps around the page until a terminate input stops it. A single-write option makes every write one beat long while reads keep the programmed length.

A new start strobe may arrive on any cycle. It discards the running burst and restarts from the new column. All outputs are registered, so the first beat appears one clock after the strobe.

Top module: `sdram_burst_colgen`

## Requirements
- R1: One cycle after `start` is high, `col_valid` is 1 and `col_out` equals the `start_col` sampled with the strobe.
- R2: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of exactly 1, 2, 4 and 8 valid beats. After the last beat, `col_valid` returns to 0 unless a new start arrives.
- R3: In a sequential burst (`interleave`=0) of length N, beat k carries the start column with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits stay unchanged.
- R4: In an interleaved burst (`interleave`=1) of length N, beat k carries the start column with its low log2(N) bits XORed with k.
- R5: With length code 3'b111 (full page), beat k carries (start_col + k) mod 2^COL_W. This holds whatever the value of `interleave`. The burst continues until `term` is sampled high.
- R6: `last_beat` is 1 only together with `col_valid`. It is high on the final beat of a fixed-length burst and never during a full-page burst.
- R7: The reserved length codes 3'b100, 3'b101 and 3'b110 behave as length 1: one beat with `last_beat` set.
- R8: When `single_write` and `is_write` are both 1 at the start strobe, the burst is one beat long whatever the length code. A read (`is_write`=0), or a write with `single_write`=0, uses the programmed length.
- R9: A start strobe during a burst restarts the sequence from the new column and the new settings on the next cycle. A strobe in the same cycle as `term` takes priority over `term`.
- R10: `term` sampled high during a burst, without a start, makes `col_valid` 0 on the next cycle.
- R11: While reset is held and after it is released, `col_valid`, `last_beat` and `col_out` are 0 until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe: load the start column and burst settings |
| start_col | input | COL_W | Starting column |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved order, 0 selects sequential |
| is_write | input | 1 | The burst being started is a write |
| single_write | input | 1 | Writes are limited to one beat |
| term | input | 1 | Stop the running burst |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | `col_out` carries a beat |
| last_beat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The hardest situations to reach from the ports are the two wraps. One is the wrap inside an aligned block when the start column sits near the top of that block. The other is the wrap of a full-page burst past the highest column back to zero. The stimulus reaches both by choosing start columns such as 0x1FD with length 8, and 0x1FA in full-page mode held for twelve beats. Restarts are driven while a burst is in flight, including a start coincident with `term`. This shows that the strobe wins and that the interleaved order resumes from the new column.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  localparam int LOG_MAX_FIXED = 3;

endpackage

// File: rtl/colgen_bl_decode.sv
module colgen_bl_decode #(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code,
  input  logic             is_write,
  input  logic             single_write,
  output logic [COL_W-1:0] mask,
  output logic             full_page
);
  import colgen_pkg::*;

  localparam int LG_W = $clog2(LOG_MAX_FIXED + 1);

  logic [LG_W-1:0] lg;
  logic            fp_raw;

  always_comb begin
    lg     = '0;
    fp_raw = 1'b0;
    case (bl_code_e'(code))
      BL_1:    lg = LG_W'(0);
      BL_2:    lg = LG_W'(1);
      BL_4:    lg = LG_W'(2);
      BL_8:    lg = LG_W'(3);
      BL_PAGE: fp_raw = 1'b1;
      default: lg = LG_W'(0);
    endcase
    if (is_write && single_write) begin
      lg     = '0;
      fp_raw = 1'b0;
    end
  end

  assign full_page = fp_raw;

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask[i] = (i < int'(lg));
  end

endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             interleave,
  input  logic             full_page,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mix;

  assign sum = base + beat;
  assign mix = base ^ beat;

  always_comb begin
    if (full_page)
      col = sum;
    else if (interleave)
      col = (base & ~mask) | (mix & mask);
    else
      col = (base & ~mask) | (sum & mask);
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             single_write,
  input  logic             term,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             last_beat
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_fp;

  logic [COL_W-1:0] base_q, mask_q, beat_q, col_q;
  logic             il_q, fp_q, valid_q, last_q;
  logic [COL_W-1:0] next_beat, next_col;

  colgen_bl_decode #(.COL_W(COL_W)) u_decode (
    .code         (bl_code),
    .is_write     (is_write),
    .single_write (single_write),
    .mask         (dec_mask),
    .full_page    (dec_fp)
  );

  assign next_beat = beat_q + 1'b1;

  colgen_addr_calc #(.COL_W(COL_W)) u_calc (
    .base       (base_q),
    .beat       (next_beat),
    .mask       (mask_q),
    .interleave (il_q),
    .full_page  (fp_q),
    .col        (next_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      beat_q  <= '0;
      col_q   <= '0;
      il_q    <= 1'b0;
      fp_q    <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (start) begin
      base_q  <= start_col;
      mask_q  <= dec_mask;
      beat_q  <= '0;
      col_q   <= start_col;
      il_q    <= interleave;
      fp_q    <= dec_fp;
      valid_q <= 1'b1;
      last_q  <= !dec_fp && (dec_mask == '0);
    end else if (valid_q && (term || last_q)) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (valid_q) begin
      beat_q  <= next_beat;
      col_q   <= next_col;
      last_q  <= !fp_q && (next_beat == mask_q);
    end
  end

  assign col_out   = col_q;
  assign col_valid = valid_q;
  assign last_beat = last_q;

  // R1
  p_start_load_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_valid && col_out == $past(start_col)));

  // R2
  p_end_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !start) |=> !col_valid);

  // R3
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !fp_q && !start && !term && !last_beat) |=>
      ((col_out & ~mask_q) == ($past(col_out) & ~$past(mask_q))));

  // R5
  p_page_step_r5: assert property (@(posedge clk) disable iff (rst)
    (col_valid && fp_q && !start && !term) |=>
      (col_valid && !last_beat && col_out == $past(col_out) + 1'b1));

  // R6
  p_last_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> col_valid);

  // R8
  p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
    (start && is_write && single_write) |=> last_beat);

  // R10
  p_term_stops_r10: assert property (@(posedge clk) disable iff (rst)
    (col_valid && term && !start) |=> !col_valid);

endmodule

// File: tb/test_sdram_burst_colgen.sv
`timescale 1ns/1ps
module test_sdram_burst_colgen;

  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = '0;
  logic             interleave = 1'b0;
  logic             is_write = 1'b0;
  logic             single_write = 1'b0;
  logic             term = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             last_beat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) i_sdram_burst_colgen (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .is_write(is_write),
    .single_write(single_write), .term(term), .col_out(col_out),
    .col_valid(col_valid), .last_beat(last_beat)
  );

  // vector: col[17:9] code[8:6] il[5] wr[4] sw[3] tag[2:0]
  localparam int NVEC = 13;
  localparam logic [17:0] VEC [NVEC] = '{
    {9'h000, 3'b000, 1'b0, 1'b0, 1'b0, 3'd0},
    {9'h005, 3'b001, 1'b0, 1'b0, 1'b0, 3'd0},
    {9'h006, 3'b010, 1'b0, 1'b0, 1'b0, 3'd1},
    {9'h1FD, 3'b011, 1'b0, 1'b0, 1'b0, 3'd1},
    {9'h0A5, 3'b011, 1'b1, 1'b0, 1'b0, 3'd2},
    {9'h013, 3'b010, 1'b1, 1'b0, 1'b0, 3'd2},
    {9'h003, 3'b001, 1'b1, 1'b0, 1'b0, 3'd2},
    {9'h040, 3'b100, 1'b0, 1'b0, 1'b0, 3'd3},
    {9'h041, 3'b101, 1'b1, 1'b0, 1'b0, 3'd3},
    {9'h042, 3'b110, 1'b0, 1'b0, 1'b0, 3'd3},
    {9'h022, 3'b011, 1'b0, 1'b1, 1'b1, 3'd4},
    {9'h022, 3'b011, 1'b0, 1'b0, 1'b1, 3'd4},
    {9'h027, 3'b010, 1'b1, 1'b1, 1'b0, 3'd4}
  };

  function automatic string tag_name(input logic [2:0] t);
    case (t)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int model_len(input logic [2:0] code, input logic wr, input logic sw);
    if (wr && sw) return 1;
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] model_col(input logic [COL_W-1:0] b, input int k,
                                                 input int len, input logic il);
    logic [COL_W-1:0] m, kk;
    kk = COL_W'(k);
    if (len == 0) return b + kk;
    m = COL_W'(len - 1);
    if (il) return (b & ~m) | ((b ^ kk) & m);
    return (b & ~m) | ((b + kk) & m);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [COL_W-1:0] c, input logic [2:0] code,
                        input logic il, input logic wr, input logic sw);
    @(negedge clk);
    start_col = c; bl_code = code; interleave = il;
    is_write = wr; single_write = sw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", int'(col_valid), 0);
    check("R11", int'(last_beat), 0);
    check("R11", int'(col_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", int'(col_valid), 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [COL_W-1:0] c;
      logic [2:0] code, tg;
      logic il, wr, sw;
      int len;
      {c, code, il, wr, sw, tg} = VEC[v];
      len = model_len(code, wr, sw);
      launch(c, code, il, wr, sw);
      check("R1", int'(col_out), int'(c));
      for (int k = 0; k < len; k++) begin
        check(tag_name(tg), int'(col_valid), 1);
        check(tag_name(tg), int'(col_out), int'(model_col(c, k, len, il)));
        check("R6", int'(last_beat), (k == len - 1) ? 1 : 0);
        @(negedge clk);
      end
      check(tag_name(tg), int'(col_valid), 0);
      check("R6", int'(last_beat), 0);
    end

    // R5: full page wraps past the top column, interleave ignored
    launch(9'h1FA, 3'b111, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) begin
      check("R5", int'(col_valid), 1);
      check("R5", int'(col_out), int'(model_col(9'h1FA, k, 0, 1'b1)));
      check("R6", int'(last_beat), 0);
      if (k < 11) @(negedge clk);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    check("R5", int'(col_valid), 0);

    // R10: term ends a fixed burst early
    launch(9'h010, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R10", int'(col_out), 9'h012);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0;
    check("R10", int'(col_valid), 0);
    check("R10", int'(last_beat), 0);

    // R9: restart mid-burst, start beats term in the same cycle
    launch(9'h030, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R9", int'(col_out), 9'h031);
    start_col = 9'h105; bl_code = 3'b010; interleave = 1'b1;
    start = 1'b1; term = 1'b1;
    @(negedge clk);
    start = 1'b0; term = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R9", int'(col_valid), 1);
      check("R9", int'(col_out), int'(model_col(9'h105, k, 4, 1'b1)));
      check("R9", int'(last_beat), (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    check("R9", int'(col_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule